// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The coalescer takes one memory instruction from a group of lanes. For each lane the instruction carries an active bit and a byte address, and the whole instruction carries one element size. The block works out which aligned 128-byte segments the active lanes touch. It then issues exactly one transaction request per distinct segment, instead of one access per lane. Each request carries:

- the segment base address;
- a lane mask, so that returned data can be steered back to the right lanes;
- each covered lane's word offset inside the segment;
- a byte mask of the bytes the covered lanes touch.

The block sits between the lane address generators and a memory request port, with a valid/ready handshake on each side. Segments are found in passes, one per cycle. In each pass the lowest-numbered lane still pending becomes the leader. Every pending lane whose segment tag matches the leader's is gathered into one request, and those lanes are retired when the request is handshaken. A one-cycle done pulse marks the end of each instruction. A counter reports how many requests the current instruction has produced.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, in_ready is 1, req_valid is 0, done is 0 and xact_count is 0.
- R2: An instruction yields exactly one request per distinct segment tag (address bits [31:7]) among its active lanes. All active lanes in one segment give 1 request; unit-stride 8-byte elements give 2; a 16-byte stride of 4-byte elements gives 4; a stride of 128 bytes or more gives 32.
- R3: Requests appear in order of their leader, the lowest-numbered lane not yet served. Each request's lane mask (bit l = lane l) holds every still-pending active lane whose tag equals the leader's.
- R4: req_base equals the leader's address with bits [6:0] cleared.
- R5: Field l of req_woff (bits [5l+4:5l]) equals address bits [6:2] of lane l when lane l is in the request, and is zero otherwise.
- R6: Bit b of req_bytes is set exactly when some covered lane with in-segment offset o satisfies o <= b < o+S. S is 1, 2, 4 or 8 bytes for in_esize codes 0, 1, 2 and 3.
- R7: Inactive lanes never appear in any lane mask and never cause a request, whatever their addresses.
- R8: While req_valid is high and req_ready is low, req_valid and all request fields stay unchanged.
- R9: in_ready is low from the cycle after acceptance until the instruction completes. done pulses for one cycle together with the handshake of the final request (req_last high), and in_ready is high again the next cycle.
- R10: An instruction with no active lanes produces no request; done pulses in the cycle after acceptance.
- R11: xact_count clears to 0 when an instruction is accepted and then counts handshaken requests. After completion it holds the instruction's total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Coalescer idle, instruction accepted when valid |
| in_active | input | 32 | Per-lane active bits |
| in_addr | input | 1024 | Lane byte addresses, lane l in bits [32l+31:32l] |
| in_esize | input | 2 | Element size code (0:1B, 1:2B, 2:4B, 3:8B) |
| req_valid | output | 1 | Transaction request offered |
| req_ready | input | 1 | Memory port accepts the request |
| req_base | output | 32 | Aligned segment base address |
| req_lanes | output | 32 | Lanes served by this request |
| req_woff | output | 160 | Per-lane 5-bit word offset in the segment |
| req_bytes | output | 128 | Bytes touched in the segment |
| req_last | output | 1 | This request is the instruction's final one |
| done | output | 1 | Instruction completion pulse |
| xact_count | output | 6 | Requests handshaken for the current instruction |

## Verification
The main function is exercised with regular strides at every element size. The strides are 0 (broadcast), unit, 16, 128 and 132 bytes, plus a unit stride that starts mid-segment. Each of these has a closed-form request count (1, 2, 4 or 32), so a wrong tag width or a wrong segment split shows up directly. Interleaved and reversed segment orders separate correct leader selection from the order in which segments first appear. Partial masks with inactive lanes pointed at fresh segments show whether inactive lanes leak into requests. Random scattered instructions under random backpressure exercise the full per-request comparison of lane masks, offsets and byte masks, together with the hold behaviour.

// File: rtl/coal_pkg.sv
package coal_pkg;

   typedef enum logic [1:0] {
      ESZ_B1 = 2'd0,
      ESZ_B2 = 2'd1,
      ESZ_B4 = 2'd2,
      ESZ_B8 = 2'd3
   } esize_e;

   // Contiguous run of ones covering one element of the given size.
   function automatic logic [7:0] elem_ones(input esize_e sz);
      case (sz)
         ESZ_B1:  elem_ones = 8'h01;
         ESZ_B2:  elem_ones = 8'h03;
         ESZ_B4:  elem_ones = 8'h0F;
         default: elem_ones = 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/coal_first_lane.sv
module coal_first_lane #(
   parameter int LANES  = 32,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic [LANES-1:0]  pend,
   output logic [LANE_W-1:0] idx,
   output logic              any
);
   // Scan downward so the lowest set bit wins.
   always_comb begin
      idx = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
         if (pend[l]) idx = LANE_W'(l);
      end
      any = |pend;
   end
endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match #(
   parameter int LANES = 32,
   parameter int TAG_W = 25
) (
   input  logic [LANES*TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]       lead_tag,
   input  logic [LANES-1:0]       pend,
   output logic [LANES-1:0]       hit
);
   for (genvar l = 0; l < LANES; l++) begin : g_cmp
      assign hit[l] = pend[l] && (tags[l*TAG_W +: TAG_W] == lead_tag);
   end
endmodule

// File: rtl/coal_byte_mask.sv
module coal_byte_mask
   import coal_pkg::*;
#(
   parameter int LANES  = 32,
   parameter int SEG_LG = 7,
   localparam int SEG_B = 1 << SEG_LG
) (
   input  logic [LANES-1:0]        hit,
   input  logic [LANES*SEG_LG-1:0] offs,
   input  esize_e                  esz,
   output logic [SEG_B-1:0]        bytes
);
   logic [SEG_B-1:0] ones;

   if (SEG_B < 8) begin : g_bad_seg
      $error("coal_byte_mask: segment must hold an 8-byte element");
   end

   assign ones = SEG_B'(elem_ones(esz));

   always_comb begin
      bytes = '0;
      for (int l = 0; l < LANES; l++) begin
         if (hit[l]) bytes = bytes | (ones << offs[l*SEG_LG +: SEG_LG]);
      end
   end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
   import coal_pkg::*;
#(
   parameter int LANES   = 32,
   parameter int ADDR_W  = 32,
   parameter int SEG_LG  = 7,
   parameter int WORD_LG = 2,
   localparam int LANE_W = $clog2(LANES),
   localparam int TAG_W  = ADDR_W - SEG_LG,
   localparam int OFF_W  = SEG_LG - WORD_LG,
   localparam int SEG_B  = 1 << SEG_LG,
   localparam int CNT_W  = $clog2(LANES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [LANES-1:0]        in_active,
   input  logic [LANES*ADDR_W-1:0] in_addr,
   input  logic [1:0]              in_esize,
   output logic                    req_valid,
   input  logic                    req_ready,
   output logic [ADDR_W-1:0]       req_base,
   output logic [LANES-1:0]        req_lanes,
   output logic [LANES*OFF_W-1:0]  req_woff,
   output logic [SEG_B-1:0]        req_bytes,
   output logic                    req_last,
   output logic                    done,
   output logic [CNT_W-1:0]        xact_count
);
   // Elaboration-time parameter checks.
   if (LANES < 2) begin : g_bad_lanes
      $error("warp_coalescer: LANES must be at least 2");
   end
   if (SEG_LG <= WORD_LG) begin : g_bad_word
      $error("warp_coalescer: segment must be wider than a word");
   end
   if (ADDR_W <= SEG_LG) begin : g_bad_addr
      $error("warp_coalescer: address narrower than a segment");
   end

   // Instruction state
   logic                    busy_q;
   logic [LANES-1:0]        pend_q;
   logic [LANES*ADDR_W-1:0] addr_q;
   esize_e                  esz_q;
   logic [CNT_W-1:0]        cnt_q;

   // Per-lane split of the held addresses
   logic [LANES*TAG_W-1:0]  tags;
   logic [LANES*SEG_LG-1:0] offs;
   logic [TAG_W-1:0]        tag_arr [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_split
      assign tag_arr[l]                  = addr_q[l*ADDR_W + SEG_LG +: TAG_W];
      assign tags[l*TAG_W +: TAG_W]      = tag_arr[l];
      assign offs[l*SEG_LG +: SEG_LG]    = addr_q[l*ADDR_W +: SEG_LG];
   end

   // Leader selection, segment match and byte mask
   logic [LANE_W-1:0] lead_idx;
   logic              lead_any;
   logic [TAG_W-1:0]  lead_tag;
   logic [LANES-1:0]  hit;

   coal_first_lane #(.LANES(LANES)) u_first (
      .pend (pend_q),
      .idx  (lead_idx),
      .any  (lead_any)
   );

   assign lead_tag = tag_arr[lead_idx];

   coal_seg_match #(.LANES(LANES), .TAG_W(TAG_W)) u_match (
      .tags     (tags),
      .lead_tag (lead_tag),
      .pend     (pend_q),
      .hit      (hit)
   );

   coal_byte_mask #(.LANES(LANES), .SEG_LG(SEG_LG)) u_bytes (
      .hit   (hit),
      .offs  (offs),
      .esz   (esz_q),
      .bytes (req_bytes)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_woff
      assign req_woff[l*OFF_W +: OFF_W] =
         hit[l] ? offs[l*SEG_LG + WORD_LG +: OFF_W] : '0;
   end

   logic fire;

   assign in_ready   = !busy_q;
   assign req_valid  = busy_q && lead_any;
   assign req_base   = {lead_tag, {SEG_LG{1'b0}}};
   assign req_lanes  = hit;
   assign req_last   = (pend_q & ~hit) == '0;
   assign fire       = req_valid && req_ready;
   assign done       = (busy_q && !lead_any) || (fire && req_last);
   assign xact_count = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= '0;
         addr_q <= '0;
         esz_q  <= ESZ_B1;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (in_valid) begin
            busy_q <= 1'b1;
            pend_q <= in_active;
            addr_q <= in_addr;
            esz_q  <= esize_e'(in_esize);
            cnt_q  <= '0;
         end
      end else if (!lead_any) begin
         busy_q <= 1'b0;
      end else if (fire) begin
         pend_q <= pend_q & ~hit;
         cnt_q  <= cnt_q + CNT_W'(1);
         if (req_last) busy_q <= 1'b0;
      end
   end

   // R8: request held under backpressure
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_base)
         && $stable(req_lanes) && $stable(req_bytes) && $stable(req_woff)));

   // R3: consecutive requests of one instruction serve disjoint lanes
   a_r3_disjoint_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_last) |=>
         (req_valid && ((req_lanes & $past(req_lanes)) == '0)));

   // R7: every request serves at least one lane
   a_r7_nonempty_mask: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_lanes != '0));

   // R9: no new instruction while requests are outstanding
   a_r9_closed_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !in_ready);

   // R9: completion reopens the input
   a_r9_reopen_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> in_ready);

   // R11: request count never exceeds the lane count
   a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      xact_count <= CNT_W'(LANES));

endmodule

// File: tb/warp_coalescer_bench.sv
`timescale 1ns/1ps
module warp_coalescer_bench;
   localparam int L = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic           in_ready;
   logic [L-1:0]   in_active = '0;
   logic [L*32-1:0] in_addr = '0;
   logic [1:0]     in_esize = '0;
   logic           req_valid;
   logic           req_ready = 1'b0;
   logic [31:0]    req_base;
   logic [L-1:0]   req_lanes;
   logic [L*5-1:0] req_woff;
   logic [127:0]   req_bytes;
   logic           req_last;
   logic           done;
   logic [5:0]     xact_count;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   warp_coalescer u_warp_coalescer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_active(in_active), .in_addr(in_addr), .in_esize(in_esize),
      .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base),
      .req_lanes(req_lanes), .req_woff(req_woff), .req_bytes(req_bytes),
      .req_last(req_last), .done(done), .xact_count(xact_count)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [159:0] got, input logic [159:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   logic [31:0] la [L];

   // Runs one instruction, compares every request against the arithmetic model.
   task automatic run_instr(input logic [L-1:0] act, input logic [1:0] esz,
                            input int exp_n, input string mreq);
      logic [L-1:0] pend;
      int n;
      int guard;
      pend = act;
      n = 0;
      guard = 0;
      @(negedge clk);
      in_valid = 1'b1;
      in_active = act;
      in_esize = esz;
      for (int l = 0; l < L; l++) in_addr[l*32 +: 32] = la[l];
      #1 chk(in_ready === 1'b1, "R9", "in_ready when idle", 160'(in_ready), 160'(1));
      @(posedge clk);
      #1 in_valid = 1'b0;
      while (guard < 400) begin
         int lead;
         logic [L-1:0] m;
         logic [L*5-1:0] wo;
         logic [127:0] by;
         logic last;
         guard++;
         @(negedge clk);
         req_ready = ($urandom % 4) != 0;
         #1;
         if (pend == '0) begin
            chk(done === 1'b1, "R10", "done for empty instruction", 160'(done), 160'(1));
            chk(req_valid === 1'b0, "R10", "no request for empty", 160'(req_valid), 160'(0));
            break;
         end
         chk(req_valid === 1'b1, "R2", "request pending", 160'(req_valid), 160'(1));
         chk(in_ready === 1'b0, "R9", "in_ready while busy", 160'(in_ready), 160'(0));
         chk(xact_count == 6'(n), "R11", "running count", 160'(xact_count), 160'(n));
         lead = 0;
         for (int l = L - 1; l >= 0; l--) if (pend[l]) lead = l;
         m = '0; wo = '0; by = '0;
         for (int l = 0; l < L; l++) begin
            if (pend[l] && la[l][31:7] == la[lead][31:7]) begin
               m[l] = 1'b1;
               wo[l*5 +: 5] = la[l][6:2];
               for (int k = 0; k < (1 << esz); k++)
                  if (int'(la[l][6:0]) + k < 128) by[int'(la[l][6:0]) + k] = 1'b1;
            end
         end
         last = (pend & ~m) == '0;
         chk(req_lanes == m, mreq, "lane mask", 160'(req_lanes), 160'(m));
         chk(req_base == {la[lead][31:7], 7'd0}, "R4", "segment base",
             160'(req_base), 160'({la[lead][31:7], 7'd0}));
         chk(req_woff == wo, "R5", "word offsets", 160'(req_woff), 160'(wo));
         chk(req_bytes == by, "R6", "byte mask", 160'(req_bytes), 160'(by));
         chk(req_last == last, "R3", "last flag", 160'(req_last), 160'(last));
         chk(done == (req_ready && last), "R9", "done pulse", 160'(done),
             160'(req_ready && last));
         if (req_ready) begin
            pend = pend & ~m;
            n++;
            if (pend == '0) break;
         end
      end
      @(negedge clk);
      #1;
      chk(xact_count == 6'(n), "R11", "final count", 160'(xact_count), 160'(n));
      chk(in_ready === 1'b1, "R9", "reopened", 160'(in_ready), 160'(1));
      chk(done === 1'b0, "R9", "done is one cycle", 160'(done), 160'(0));
      if (exp_n >= 0)
         chk(n == exp_n, "R2", "request total", 160'(n), 160'(exp_n));
   endtask

   task automatic stride_instr(input logic [31:0] base, input int stride,
                               input logic [1:0] esz, input int exp_n);
      for (int l = 0; l < L; l++) la[l] = base + 32'(l * stride);
      run_instr('1, esz, exp_n, "R3");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R9 watchdog: got hang expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(in_ready === 1'b1, "R1", "in_ready in reset", 160'(in_ready), 160'(1));
      chk(req_valid === 1'b0, "R1", "req_valid in reset", 160'(req_valid), 160'(0));
      chk(done === 1'b0, "R1", "done in reset", 160'(done), 160'(0));
      chk(xact_count == 6'd0, "R1", "count in reset", 160'(xact_count), 160'(0));
      @(negedge clk);
      rst_n = 1'b1;

      // R2: closed-form request counts
      stride_instr(32'h0000_1000, 4,   2'd2, 1);
      stride_instr(32'h0000_2000, 8,   2'd3, 2);
      stride_instr(32'h0000_3040, 2,   2'd1, 1);
      stride_instr(32'h0000_4000, 16,  2'd2, 4);
      stride_instr(32'h0001_0000, 128, 2'd2, 32);
      stride_instr(32'h0002_0000, 132, 2'd2, 32);
      stride_instr(32'h0000_5554, 0,   2'd2, 1);
      stride_instr(32'h0000_6040, 4,   2'd2, 2);
      stride_instr(32'h0000_7000, 1,   2'd0, 1);
      stride_instr(32'hFFFF_FF80, 4,   2'd2, 1);

      // R3: reversed and interleaved segment order
      for (int l = 0; l < L; l++) la[l] = 32'h0003_0000 + 32'((31 - l) * 128);
      run_instr('1, 2'd2, 32, "R3");
      for (int l = 0; l < L; l++) la[l] = 32'h0004_0000 + 32'((l % 3) * 4096 + l * 4);
      run_instr('1, 2'd2, 3, "R3");

      // R7: inactive lanes aimed at fresh segments
      for (int l = 0; l < L; l++)
         la[l] = (l < 16) ? 32'h0000_5000 + 32'(l * 4) : 32'h0009_0000 + 32'(l * 128);
      run_instr(32'h0000_FFFF, 2'd2, 1, "R7");
      for (int l = 0; l < L; l++) la[l] = 32'h000A_0000 + 32'(l * 256);
      run_instr(32'h8000_0001, 2'd3, 2, "R7");

      // R10: nothing active
      for (int l = 0; l < L; l++) la[l] = 32'(l * 512);
      run_instr('0, 2'd2, 0, "R10");

      // Random scattered instructions over a few segments
      for (int t = 0; t < 40; t++) begin
         logic [1:0] esz;
         logic [31:0] segs [4];
         esz = 2'($urandom % 4);
         for (int s = 0; s < 4; s++) segs[s] = {$urandom, 7'd0} & 32'hFFFF_FF80;
         for (int l = 0; l < L; l++)
            la[l] = segs[$urandom % 4] + 32'((($urandom % (128 >> esz))) << esz);
         run_instr((t % 5 == 0) ? '1 : L'($urandom), esz, -1, "R3");
      end

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule